// File: doc/BRIEF.md
# Low-Power Mode Permission Register

This block is a single 16-bit control word on a simple register bus. The core uses it to decide whether its stop and wait instructions really enter their low-power modes. Each of the two mode fields is two bits wide. The low bit, when set, makes the matching instruction have no effect. The high bit, when written as 1, freezes that field until the next system reset.

The same word also holds two more controls. One is a write-only trigger that sends a one-cycle device-reset request. The other is a select that either keeps the core's debug clock on all the time or lets it follow the debug port's own enable. Reads have no side effects, and reading any address other than the register's own returns zero.

Each mode field is a small state machine with two states. `FLD_OPEN` is the reset state and accepts writes. `FLD_LOCKED` ignores all writes. The field moves from `FLD_OPEN` to `FLD_LOCKED` on a write whose high field bit is 1. The only way out of `FLD_LOCKED` is the system reset. The reset trigger is a second state machine. It sits in `RST_IDLE`, goes to `RST_FIRE` for one cycle after a write that sets the trigger bit, and stays in `RST_FIRE` only while such writes continue back to back.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the register reads 0x0000, `swrst_pulse` is 0, neither field is locked, and both low-power modes are allowed.
- R2: Bits 15..6 of the register always read 0, whatever value is written to them.
- R3: When bit 5 is 1, `dbg_clk_en` is 1. When bit 5 is 0, `dbg_clk_en` equals `dbg_port_en`. Bit 5 reads back the value written.
- R4: A write to the register with bit 4 set drives `swrst_pulse` high for exactly the clock cycle after the write edge. Bit 4 always reads 0.
- R5: `stop_enter` is 1 only when `core_stop_req` is 1 and bit 2 (stop ignore) is 0.
- R6: `wait_enter` is 1 only when `core_wait_req` is 1 and bit 0 (wait ignore) is 0.
- R7: A write with bit 3 set locks the stop field (bits 3..2). It then reads with bit 3 = 1, and later writes leave bits 3..2 unchanged until reset.
- R8: A write with bit 1 set locks the wait field (bits 1..0). It then reads with bit 1 = 1, and later writes leave bits 1..0 unchanged until reset.
- R9: A write that touches a locked field still updates every unlocked field and bit in the same access.
- R10: While `bus_addr` is not REG_ADDR (0), `bus_rdata` is 0 and writes change nothing.
- R11: Asserting `rst_n` clears both locks and all stored bits, so a field that was locked can be written again afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| dbg_port_en | input | 1 | Enable from the debug port |
| core_stop_req | input | 1 | Core is executing a stop instruction |
| core_wait_req | input | 1 | Core is executing a wait instruction |
| stop_enter | output | 1 | Permission to enter Stop mode |
| wait_enter | output | 1 | Permission to enter Wait mode |
| swrst_pulse | output | 1 | One-cycle device-reset request |
| dbg_clk_en | output | 1 | Core debug clock enable |

## Verification
The bench tests three things the locks must get right. A locked field must ignore a clearing write, the lock must not spread to the other field, and one access that hits both a locked and an unlocked field must still update the unlocked one. A design that treated the lock as one shared bit, or that dropped the whole write, would show a wrong `bus_rdata` right after such an access.

The reset trigger is checked on every cycle against the model. A design that latched it or stretched it would show `swrst_pulse` high for a second cycle, or a 1 in bit 4 on readback. The bench also writes to an unmapped address with data that would change the fields, and writes ones into the reserved bits. Either mistake would show up as a nonzero read.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Bit positions the core-side logic decodes
    localparam int WAIT_LSB  = 0;
    localparam int STOP_LSB  = 2;
    localparam int SWRST_BIT = 4;
    localparam int DBG_BIT   = 5;
    localparam int USED_BITS = 6;

    typedef enum logic {
        FLD_OPEN   = 1'b0,
        FLD_LOCKED = 1'b1
    } fld_state_t;

    typedef enum logic {
        RST_IDLE = 1'b0,
        RST_FIRE = 1'b1
    } rst_state_t;

endpackage

// File: rtl/pmc_mode_field.sv
module pmc_mode_field
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_lock,
    input  logic wr_ign,
    output logic ign_o,
    output logic lk_o
);

    fld_state_t st_q, st_d;
    logic       ign_q, ign_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLD_OPEN;
            ign_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ign_q <= ign_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        ign_d = ign_q;
        unique case (st_q)
            FLD_OPEN: begin
                if (wr_en) begin
                    ign_d = wr_ign;
                    if (wr_lock) st_d = FLD_LOCKED;
                end
            end
            FLD_LOCKED: begin
                st_d = FLD_LOCKED;
            end
            default: st_d = FLD_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        ign_o = ign_q;
        lk_o  = (st_q == FLD_LOCKED);
    end

    // R7 R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_o |=> lk_o);

    // R7 R8
    locked_value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_o |=> $stable(ign_o));

endmodule

// File: rtl/pmc_swrst_gen.sv
module pmc_swrst_gen
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_o
);

    rst_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RST_IDLE: if (trig)  st_d = RST_FIRE;
            RST_FIRE: if (!trig) st_d = RST_IDLE;
            default:  st_d = RST_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = (st_q == RST_FIRE);
    end

    // R4
    pulse_from_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse_o);

    // R4
    pulse_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> !pulse_o);

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_port_en,
    input  logic              core_stop_req,
    input  logic              core_wait_req,
    output logic              stop_enter,
    output logic              wait_enter,
    output logic              swrst_pulse,
    output logic              dbg_clk_en
);

    localparam int NUM_FLD = 2;
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic               addr_hit;
    logic               wr_hit;
    logic [NUM_FLD-1:0] fld_ign;
    logic [NUM_FLD-1:0] fld_lk;
    logic               dbg_sel_q;
    logic [DATA_W-1:0]  rd_word;

    assign addr_hit = (bus_addr == HIT_ADDR);
    assign wr_hit   = addr_hit && bus_we;

    // Field 0 = wait (bits 1..0), field 1 = stop (bits 3..2)
    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        localparam int LSB = (g == 0) ? WAIT_LSB : STOP_LSB;
        pmc_mode_field u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_lock (bus_wdata[LSB+1]),
            .wr_ign  (bus_wdata[LSB]),
            .ign_o   (fld_ign[g]),
            .lk_o    (fld_lk[g])
        );
    end

    pmc_swrst_gen u_swrst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (wr_hit && bus_wdata[SWRST_BIT]),
        .pulse_o (swrst_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dbg_sel_q <= 1'b0;
        else if (wr_hit) dbg_sel_q <= bus_wdata[DBG_BIT];
    end

    always_comb begin
        rd_word              = '0;
        rd_word[WAIT_LSB]    = fld_ign[0];
        rd_word[WAIT_LSB+1]  = fld_lk[0];
        rd_word[STOP_LSB]    = fld_ign[1];
        rd_word[STOP_LSB+1]  = fld_lk[1];
        rd_word[DBG_BIT]     = dbg_sel_q;
        bus_rdata            = addr_hit ? rd_word : '0;
    end

    assign wait_enter = core_wait_req && !fld_ign[0];
    assign stop_enter = core_stop_req && !fld_ign[1];
    assign dbg_clk_en = dbg_sel_q || dbg_port_en;

    // R2
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (|bus_wdata[DATA_W-1:USED_BITS])) |=>
            (bus_rdata[DATA_W-1:USED_BITS] == '0));

    // R4
    swrst_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_pulse |-> !bus_rdata[SWRST_BIT]);

    // R5
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |-> core_stop_req);

    // R6
    wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_enter |-> core_wait_req);

    // R3
    dbg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_port_en |-> dbg_clk_en);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> (bus_rdata == '0));

endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;

    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          dbg_port_en = 1'b0;
    logic          core_stop_req = 1'b0;
    logic          core_wait_req = 1'b0;
    logic          stop_enter, wait_enter, swrst_pulse, dbg_clk_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwr_mode_ctl #(.ADDR_W(AW), .DATA_W(DW), .REG_ADDR(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_port_en(dbg_port_en),
        .core_stop_req(core_stop_req), .core_wait_req(core_wait_req),
        .stop_enter(stop_enter), .wait_enter(wait_enter),
        .swrst_pulse(swrst_pulse), .dbg_clk_en(dbg_clk_en)
    );

    // Behavioural reference model
    int m_stop_ign, m_stop_lk, m_wait_ign, m_wait_lk, m_dbg, m_swrst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stop_ign = 0; m_stop_lk = 0; m_wait_ign = 0; m_wait_lk = 0;
            m_dbg = 0; m_swrst = 0;
        end else begin
            m_swrst = 0;
            if (bus_we && bus_addr == 0) begin
                if (m_stop_lk == 0) begin
                    m_stop_ign = bus_wdata[2];
                    m_stop_lk  = bus_wdata[3];
                end
                if (m_wait_lk == 0) begin
                    m_wait_ign = bus_wdata[0];
                    m_wait_lk  = bus_wdata[1];
                end
                m_dbg   = bus_wdata[5];
                m_swrst = bus_wdata[4];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Cycle compare
    always @(negedge clk) begin
        if (!done) begin
            int exp_rd;
            exp_rd = (bus_addr == 0) ?
                     (m_dbg * 32 + m_stop_lk * 8 + m_stop_ign * 4 + m_wait_lk * 2 + m_wait_ign) : 0;
            chk("R2/R3/R7/R8/R9/R10 model rdata", int'(bus_rdata), exp_rd);
            chk("R4 model swrst_pulse", int'(swrst_pulse), m_swrst);
            chk("R5 model stop_enter", int'(stop_enter), int'(core_stop_req && m_stop_ign == 0));
            chk("R6 model wait_enter", int'(wait_enter), int'(core_wait_req && m_wait_ign == 0));
            chk("R3 model dbg_clk_en", int'(dbg_clk_en), int'(m_dbg != 0 || dbg_port_en));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input int exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, int'(bus_rdata), exp);
        bus_addr = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        core_stop_req = 1'b1; core_wait_req = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata after reset", int'(bus_rdata), 0);
        chk("R1 swrst after reset", int'(swrst_pulse), 0);
        chk("R1 stop allowed", int'(stop_enter), 1);
        chk("R1 wait allowed", int'(wait_enter), 1);

        // R2 reserved bits
        wr(0, 16'hFFC0);
        rd_chk("R2 reserved read zero", 0, 0);

        // R3 debug clock select
        wr(0, 16'h0020);
        @(negedge clk);
        chk("R3 forced on", int'(dbg_clk_en), 1);
        rd_chk("R3 readback", 0, 'h20);
        wr(0, 16'h0000);
        dbg_port_en = 1'b1;
        @(negedge clk);
        chk("R3 follows port high", int'(dbg_clk_en), 1);
        dbg_port_en = 1'b0;
        @(negedge clk);
        chk("R3 follows port low", int'(dbg_clk_en), 0);

        // R4 software reset pulse
        @(posedge clk); #1;
        bus_we = 1'b1; bus_wdata = 16'h0010;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
        chk("R4 pulse high", int'(swrst_pulse), 1);
        chk("R4 bit reads zero", int'(bus_rdata[4]), 0);
        @(posedge clk); #1;
        chk("R4 pulse single cycle", int'(swrst_pulse), 0);

        // R5 stop ignore
        wr(0, 16'h0004);
        @(negedge clk);
        chk("R5 stop ignored", int'(stop_enter), 0);
        chk("R5 wait unaffected", int'(wait_enter), 1);
        wr(0, 16'h0000);

        // R6 wait ignore
        wr(0, 16'h0001);
        @(negedge clk);
        chk("R6 wait ignored", int'(wait_enter), 0);
        chk("R6 stop unaffected", int'(stop_enter), 1);
        wr(0, 16'h0000);

        // R10 unmapped address
        wr(3, 16'h002F);
        rd_chk("R10 unmapped read", 3, 0);
        rd_chk("R10 unmapped write no effect", 0, 0);

        // R7 stop lock
        wr(0, 16'h000C);
        wr(0, 16'h0000);
        rd_chk("R7 stop held after lock", 0, 'h0C);
        @(negedge clk);
        chk("R7 stop still ignored", int'(stop_enter), 0);

        // R8 wait lock, R9 mixed access
        wr(0, 16'h0002);
        wr(0, 16'h0021);
        rd_chk("R9 dbg updates beside locks", 0, 'h2E);
        wr(0, 16'h0000);
        rd_chk("R8 wait held after lock", 0, 'h0E);
        @(negedge clk);
        chk("R8 wait allowed while locked", int'(wait_enter), 1);

        // R11 reset clears locks
        @(posedge clk); #2;
        rst_n = 1'b0;
        #1;
        chk("R11 rdata during reset", int'(bus_rdata), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        wr(0, 16'h0005);
        rd_chk("R11 field writable after reset", 0, 'h05);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule